// File: doc/BRIEF.md
# Sync Noise Counter Detector

This block judges how clean the incoming composite sync is, so that a tuner can tell when it is locked onto a station. A horizontal timing counter outside the block supplies an oscillator pulse and a line-position count. From these the block builds a noise window. The window opens when the oscillator pulse falls and closes at a programmable line position. Each line counts as noisy if a composite-sync rising edge lands while the window is open, or if no rising edge lands in the part of the line where the window is closed.

Noisy lines are counted in a saturating counter, and the count is always visible on an output. The counter is cleared on every second vertical-sync rising edge, so the count covers the noise of one field. When an increment brings the count to a programmable level, a sticky interrupt flag is raised. Software clears the flag with a one-cycle strobe. When the internal horizontal reference and the text display mode are both active, the field clear happens only if a dedicated enable bit is set.

All pins are plain control and status signals sampled on `clk`. No data stream passes through the block, so it has no valid/ready handshake and no back-pressure.

Top module: `snd_noise_detect`

## Requirements
- R1: While `rst_n` is low and on the first cycle after release, `noise_cnt` is 0 and `noise_irq` is 0.
- R2: The window is set on the clock edge where `hosc` is sampled low after having been sampled high. It is cleared on an edge where `hpos` equals `win_clr`. If both happen on the same edge, set wins.
- R3: A line in which a `csync` rising edge is sampled while the window is high counts as noisy.
- R4: A line in which no `csync` rising edge is sampled while the window is low counts as noisy. A line with a rising edge only in the low portion is clean.
- R5: A line is judged on the `hosc` falling edge that ends it and adds at most one to the count. That edge also starts the next line. The first `hosc` falling edge after reset only starts a line.
- R6: `noise_cnt` saturates at its all-ones value and never wraps.
- R7: `noise_irq` is set on the edge where an increment makes `noise_cnt` equal to `level`. A `level` of 0 never sets it.
- R8: `noise_irq` stays set until `flag_clr` is sampled high. A set on the same edge as `flag_clr` leaves it set.
- R9: Counting `vsync` rising edges from reset, the 2nd, 4th, 6th and later even ones clear `noise_cnt` to 0. This clear beats an increment on the same edge.
- R10: When `int_ref` and `text_mode` are both 1, an even `vsync` edge clears the count only if `rst_en` is 1. The odd/even sequence advances on every `vsync` rising edge either way.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| csync | input | 1 | Composite sync level |
| hosc | input | 1 | Horizontal oscillator pulse from the line counter |
| vsync | input | 1 | Vertical sync level |
| hpos | input | POS_W (7) | Current line position |
| win_clr | input | POS_W (7) | Line position that closes the window |
| level | input | CNT_W (8) | Detection level; 0 disables the flag |
| int_ref | input | 1 | Internal horizontal reference selected |
| text_mode | input | 1 | Text display mode active |
| rst_en | input | 1 | Allows the field clear when both above are 1 |
| flag_clr | input | 1 | One-cycle clear of the interrupt flag |
| noise_cnt | output | CNT_W (8) | Current noise count |
| noise_irq | output | 1 | Sticky interrupt request flag |

## Verification
The bench plays whole lines that are clean, that have a pulse inside the window, that have no pulse in the closed portion, and that have both faults at once. These patterns separate the two noise rules and show that one line adds only one. A line whose pulse the window position pushes into the closed portion checks the window clear point. Vertical-sync sequences are played with and without the mode gating and with a clear landing on a judging edge, which separates odd edges from even ones and shows which of clear and increment wins. A run of several hundred noisy lines with the level at zero checks saturation and that a zero level never raises the flag.

// File: rtl/snd_pkg.sv
package snd_pkg;
  typedef struct packed {
    logic sync_rise;
    logic line_end;
    logic field_rise;
  } snd_evt_t;
endpackage

// File: rtl/snd_edges.sv
module snd_edges #(
  parameter int N = 3,
  parameter logic [N-1:0] FALL_MASK = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] sig,
  output logic [N-1:0] evt
);
  logic [N-1:0] sig_q;

  always_ff @(posedge clk) begin
    if (!rst_n) sig_q <= '0;
    else        sig_q <= sig;
  end

  for (genvar i = 0; i < N; i++) begin : g_bit
    if (FALL_MASK[i]) begin : g_fall
      assign evt[i] = sig_q[i] & ~sig[i];
    end else begin : g_rise
      assign evt[i] = sig[i] & ~sig_q[i];
    end
  end
endmodule

// File: rtl/snd_line_judge.sv
module snd_line_judge #(
  parameter int POS_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sync_rise,
  input  logic             line_end,
  input  logic [POS_W-1:0] hpos,
  input  logic [POS_W-1:0] win_clr,
  output logic             line_noisy
);
  logic win, hit_open_q, hit_shut_q, armed;
  logic hit_open, hit_shut;

  // Fold in a pulse arriving on the judging edge itself.
  assign hit_open   = hit_open_q | (sync_rise & win);
  assign hit_shut   = hit_shut_q | (sync_rise & ~win);
  assign line_noisy = line_end & armed & (hit_open | ~hit_shut);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      win        <= 1'b0;
      hit_open_q <= 1'b0;
      hit_shut_q <= 1'b0;
      armed      <= 1'b0;
    end else if (line_end) begin
      win        <= 1'b1;
      hit_open_q <= 1'b0;
      hit_shut_q <= 1'b0;
      armed      <= 1'b1;
    end else begin
      if (hpos == win_clr) win <= 1'b0;
      hit_open_q <= hit_open;
      hit_shut_q <= hit_shut;
    end
  end
endmodule

// File: rtl/snd_field_gate.sv
module snd_field_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic field_rise,
  input  logic int_ref,
  input  logic text_mode,
  input  logic rst_en,
  output logic field_clr
);
  logic even_next;
  logic allow;

  assign allow     = ~(int_ref & text_mode) | rst_en;
  assign field_clr = field_rise & even_next & allow;

  always_ff @(posedge clk) begin
    if (!rst_n)          even_next <= 1'b0;
    else if (field_rise) even_next <= ~even_next;
  end
endmodule

// File: rtl/snd_counter.sv
module snd_counter #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             line_noisy,
  input  logic             field_clr,
  input  logic [CNT_W-1:0] level,
  input  logic             flag_clr,
  output logic [CNT_W-1:0] cnt,
  output logic             irq
);
  logic             at_max, bump, hit_level;
  logic [CNT_W-1:0] cnt_nxt;

  assign at_max    = &cnt;
  assign bump      = line_noisy & ~at_max & ~field_clr;
  assign cnt_nxt   = cnt + 1'b1;
  assign hit_level = bump & (cnt_nxt == level);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0;
      irq <= 1'b0;
    end else begin
      if (field_clr) cnt <= '0;
      else if (bump) cnt <= cnt_nxt;
      irq <= hit_level | (irq & ~flag_clr);
    end
  end
endmodule

// File: rtl/snd_noise_detect.sv
module snd_noise_detect #(
  parameter int POS_W = 7,
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             csync,
  input  logic             hosc,
  input  logic             vsync,
  input  logic [POS_W-1:0] hpos,
  input  logic [POS_W-1:0] win_clr,
  input  logic [CNT_W-1:0] level,
  input  logic             int_ref,
  input  logic             text_mode,
  input  logic             rst_en,
  input  logic             flag_clr,
  output logic [CNT_W-1:0] noise_cnt,
  output logic             noise_irq
);
  import snd_pkg::*;

  snd_evt_t evt;
  logic     line_noisy, field_clr;

  snd_edges #(.N(3), .FALL_MASK(3'b010)) u_edges (
    .clk(clk), .rst_n(rst_n),
    .sig({vsync, hosc, csync}),
    .evt({evt.field_rise, evt.line_end, evt.sync_rise})
  );

  snd_line_judge #(.POS_W(POS_W)) u_judge (
    .clk(clk), .rst_n(rst_n),
    .sync_rise(evt.sync_rise), .line_end(evt.line_end),
    .hpos(hpos), .win_clr(win_clr), .line_noisy(line_noisy)
  );

  snd_field_gate u_gate (
    .clk(clk), .rst_n(rst_n), .field_rise(evt.field_rise),
    .int_ref(int_ref), .text_mode(text_mode), .rst_en(rst_en),
    .field_clr(field_clr)
  );

  snd_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .line_noisy(line_noisy),
    .field_clr(field_clr), .level(level), .flag_clr(flag_clr),
    .cnt(noise_cnt), .irq(noise_irq)
  );
endmodule

// File: rtl/snd_noise_detect_chk.sv
module snd_noise_detect_chk #(
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             hosc,
  input logic             vsync,
  input logic [CNT_W-1:0] level,
  input logic             int_ref,
  input logic             text_mode,
  input logic             rst_en,
  input logic             flag_clr,
  input logic [CNT_W-1:0] noise_cnt,
  input logic             noise_irq
);
  localparam logic [CNT_W-1:0] TOP = {CNT_W{1'b1}};

  p_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (noise_cnt != TOP) |=> (noise_cnt == $past(noise_cnt)) ||
      (noise_cnt == $past(noise_cnt) + 1'b1) || (noise_cnt == '0));

  p_line_end_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (noise_cnt > $past(noise_cnt)) |-> (!$past(hosc) && $past(hosc, 2)));

  p_no_wrap_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (noise_cnt == TOP) |=> (noise_cnt == TOP) || (noise_cnt == '0));

  p_set_at_level_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(noise_irq) |-> (noise_cnt == $past(level)) && ($past(level) != '0));

  p_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (noise_irq && !flag_clr) |=> noise_irq);

  p_clear_on_vsync_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (noise_cnt == '0 && $past(noise_cnt) != '0) |-> ($past(vsync) && !$past(vsync, 2)));

  p_gated_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(noise_cnt) != '0 && $past(int_ref) && $past(text_mode) && !$past(rst_en))
      |-> (noise_cnt != '0));
endmodule

bind snd_noise_detect snd_noise_detect_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .hosc(hosc), .vsync(vsync), .level(level),
  .int_ref(int_ref), .text_mode(text_mode), .rst_en(rst_en),
  .flag_clr(flag_clr), .noise_cnt(noise_cnt), .noise_irq(noise_irq)
);

// File: tb/snd_noise_detect_tb.sv
`timescale 1ns/1ps
module snd_noise_detect_tb;
  localparam int LINE = 32;
  localparam int CMAX = 255;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       csync = 0, hosc = 0, vsync = 0;
  logic [6:0] hpos = '0, win_clr = 7'd16;
  logic [7:0] level = 8'd3;
  logic       int_ref = 0, text_mode = 0, rst_en = 0, flag_clr = 0;
  logic [7:0] noise_cnt;
  logic       noise_irq;

  int checks = 0, fails = 0;
  bit done = 0;

  always #2 clk = ~clk;

  snd_noise_detect u_dut (
    .clk(clk), .rst_n(rst_n), .csync(csync), .hosc(hosc), .vsync(vsync),
    .hpos(hpos), .win_clr(win_clr), .level(level), .int_ref(int_ref),
    .text_mode(text_mode), .rst_en(rst_en), .flag_clr(flag_clr),
    .noise_cnt(noise_cnt), .noise_irq(noise_irq)
  );

  // Behavioural reference model, updated on each rising edge.
  bit m_cs, m_hs, m_vs, m_open, m_hit_open, m_hit_shut, m_armed, m_even, m_irq;
  int m_cnt;

  always @(posedge clk) begin
    bit pulse, lend, vrise, ho, hs, noisy, fclr, step;
    if (!rst_n) begin
      m_cs = 0; m_hs = 0; m_vs = 0; m_open = 0; m_hit_open = 0; m_hit_shut = 0;
      m_armed = 0; m_even = 0; m_irq = 0; m_cnt = 0;
    end else begin
      pulse = csync && !m_cs;
      lend  = m_hs && !hosc;
      vrise = vsync && !m_vs;
      ho    = m_hit_open || (pulse && m_open);
      hs    = m_hit_shut || (pulse && !m_open);
      noisy = lend && m_armed && (ho || !hs);
      fclr  = vrise && m_even && (!(int_ref && text_mode) || rst_en);
      step  = noisy && !fclr && (m_cnt < CMAX);
      m_irq = (step && (m_cnt + 1 == int'(level))) || (m_irq && !flag_clr);
      if (fclr) m_cnt = 0;
      else if (step) m_cnt = m_cnt + 1;
      if (vrise) m_even = !m_even;
      if (lend) begin
        m_open = 1; m_hit_open = 0; m_hit_shut = 0; m_armed = 1;
      end else begin
        if (hpos == win_clr) m_open = 0;
        m_hit_open = ho; m_hit_shut = hs;
      end
      m_cs = csync; m_hs = hosc; m_vs = vsync;
    end
  end

  always @(negedge clk) begin
    if (!done) begin
      checks++;
      if (int'(noise_cnt) != m_cnt) begin
        fails++;
        $display("FAIL R5 per-cycle count: actual %0d expected %0d", noise_cnt, m_cnt);
      end
      checks++;
      if (noise_irq != m_irq) begin
        fails++;
        $display("FAIL R7 per-cycle flag: actual %0d expected %0d", noise_irq, m_irq);
      end
    end
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // One line: pulse at 5 (window open) and/or at 22 (window shut).
  task automatic drive_line(input bit in_open, input bit in_shut,
                            input int vpos, input int clrpos);
    for (int p = 0; p < LINE; p++) begin
      @(negedge clk);
      hpos     = 7'(p);
      hosc     = (p >= 28);
      csync    = (in_open && (p == 5 || p == 6)) || (in_shut && (p == 22 || p == 23));
      vsync    = (vpos >= 0) && (p == vpos || p == vpos + 1);
      flag_clr = (p == clrpos);
    end
  endtask

  task automatic good(input int vpos = -1, input int clrpos = -1);
    drive_line(0, 1, vpos, clrpos);
  endtask

  task automatic finish_run();
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    check("R1 count in reset", int'(noise_cnt), 0);
    check("R1 flag in reset", int'(noise_irq), 0);
    @(negedge clk); rst_n = 1;
    @(negedge clk);
    check("R1 count after release", int'(noise_cnt), 0);

    good(); good(); good();
    check("R4 clean lines", int'(noise_cnt), 0);
    check("R5 first edge only arms", int'(noise_cnt), 0);

    drive_line(1, 1, -1, -1); good();
    check("R3 pulse in open window", int'(noise_cnt), 1);

    drive_line(0, 0, -1, -1); good();
    check("R4 missing pulse in shut portion", int'(noise_cnt), 2);

    drive_line(1, 0, -1, -1); good();
    check("R5 both faults add one", int'(noise_cnt), 3);
    check("R7 flag at level 3", int'(noise_irq), 1);

    good(-1, 10);
    check("R8 strobe clears flag", int'(noise_irq), 0);

    level = 8'd4;
    drive_line(1, 1, -1, -1); good(-1, 0);
    check("R8 set beats clear", int'(noise_irq), 1);
    check("R7 count at new level", int'(noise_cnt), 4);
    good(); good();
    check("R8 flag sticky", int'(noise_irq), 1);

    win_clr = 7'd3;
    drive_line(1, 0, -1, -1);
    win_clr = 7'd16;
    good();
    check("R2 early close makes pulse clean", int'(noise_cnt), 4);

    good(10);
    check("R9 first vsync keeps count", int'(noise_cnt), 4);
    good(10);
    check("R9 second vsync clears", int'(noise_cnt), 0);
    good(10);
    drive_line(1, 1, -1, -1); good(0);
    check("R9 clear beats increment", int'(noise_cnt), 0);

    int_ref = 1; text_mode = 1; rst_en = 0;
    drive_line(1, 1, -1, -1); good(10);
    check("R10 count before gated field", int'(noise_cnt), 1);
    good(10);
    check("R10 gated clear blocked", int'(noise_cnt), 1);
    rst_en = 1;
    good(10); good(10);
    check("R10 enabled clear", int'(noise_cnt), 0);

    int_ref = 0; text_mode = 0; rst_en = 0; level = 8'd0;
    good(-1, 5);
    check("R8 flag cleared before saturation", int'(noise_irq), 0);
    for (int i = 0; i < 260; i++) drive_line(1, 1, -1, -1);
    good();
    check("R6 saturates", int'(noise_cnt), CMAX);
    check("R7 level zero never sets", int'(noise_irq), 0);

    finish_run();
  end
endmodule